// File: doc/BRIEF.md
# Event Frame Formatter with Header and Trailer

This block collects the raw 32-bit data words of one triggered detector event and hands them on as a self-describing frame, ready to be written into a memory buffer. An event opens with a one-cycle start strobe and closes with a one-cycle end strobe. Between the two, payload words arrive on a valid/ready input stream. The block keeps three counters: a free-running cycle timestamp, a spill counter and a per-spill event counter. A spill is the beam period; a strobe marks the start of each one.

The header has to state the total length before any payload word leaves. For that reason the whole payload is held in an internal buffer. When the end strobe arrives, the block emits five header words, the buffered payload in its original order, and three trailer words, all on a 32-bit valid/ready output that may be stalled at any time. Only one event is handled at a time. The input stream is closed while a frame waits or drains, so nothing is lost silently. A payload longer than the buffer is cut at the buffer depth, and the trailer reports the cut.

Top module: `evt_framer`

## Requirements
- R1: Each frame is exactly 5 header words, then the N stored payload words in their order of arrival, then 3 trailer words. An event with no payload gives an 8-word frame. out_valid_o is low outside frames.
- R2: Header word 0 holds the frame length in bytes, 4*(8+N). Trailer word 1 holds the payload length in bytes, 4*N.
- R3: Header word 1 holds the readout duration: the number of clock edges from the edge that samples the start strobe to the edge that samples the end strobe.
- R4: Header word 4 holds the arrival time. This is the timestamp value at the edge that samples the start strobe. The timestamp is 0 at reset release and then increases by 1 on every clock edge.
- R5: Header word 2 holds the event number: the count of events ended since the last spill strobe, so the first event of a spill is 0. Header word 3 holds the spill number: the count of spill strobes since reset.
- R6: Trailer word 0 is the marker constant MARKER, 32'hEEEE_EEEE by default.
- R7: Payload words beyond DEPTH (default 256) are still accepted but dropped. N is then DEPTH, and trailer word 2 has bit 0 (overflow) set. Trailer word 2 is 0 when the payload fits, including exactly DEPTH words.
- R8: While out_valid_o is high and out_ready_i is low, out_valid_o stays high and out_data_o holds its value. No frame word is dropped or repeated.
- R9: in_ready_o is high only while an event is being collected, never while a frame is output. A start strobe during collection or emission is ignored, an end strobe outside collection is ignored, and data offered while in_ready_o is low never appears in a frame.
- R10: During reset, out_valid_o and in_ready_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spill_i | input | 1 | One-cycle strobe marking a new spill |
| evt_start_i | input | 1 | One-cycle strobe opening an event |
| evt_end_i | input | 1 | One-cycle strobe closing an event |
| in_valid_i | input | 1 | Payload word valid |
| in_data_i | input | 32 | Payload word |
| in_ready_o | output | 1 | High while payload is being collected |
| out_valid_o | output | 1 | Frame word valid |
| out_data_o | output | 32 | Frame word |
| out_ready_i | input | 1 | Downstream accepts the frame word |

## Verification
The hardest situations to reach from the ports are buffer overflow and strobes or data that arrive while a finished event waits to be output. To reach overflow, the bench streams an event of DEPTH+5 words and also one of exactly DEPTH words, which sits on the boundary. To reach the second case, the bench raises a start strobe and valid data two cycles after an end strobe, while the frame is held in the block. A pseudo-random ready pattern stretches the drain so that stalls fall on header, payload and trailer words. The scoreboard then shows whether any of the stray data leaked into a frame and whether the counters moved.

// File: rtl/evt_framer_pkg.sv
package evt_framer_pkg;

  typedef enum logic [1:0] {
    COL_IDLE = 2'd0,
    COL_RUN  = 2'd1,
    COL_HOLD = 2'd2
  } col_state_e;

  typedef enum logic [1:0] {
    EM_IDLE = 2'd0,
    EM_HDR  = 2'd1,
    EM_PAY  = 2'd2,
    EM_TRL  = 2'd3
  } em_phase_e;

  localparam int HDR_WORDS   = 5;
  localparam int TRL_WORDS   = 3;
  localparam int OVH_WORDS   = HDR_WORDS + TRL_WORDS;
  localparam int ERR_OVF_BIT = 0;

endpackage

// File: rtl/evt_buf.sv
module evt_buf #(
  parameter int DEPTH = 256,
  parameter int W     = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [W-1:0]  wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [W-1:0]  rd_data_o
);

  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en_i) begin
      mem_q[wr_addr_i] <= wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];

endmodule

// File: rtl/evt_collect.sv
module evt_collect
  import evt_framer_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int W     = 32,
  parameter int CNT_W = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int WCW  = AW + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           spill_i,
  input  logic           start_i,
  input  logic           end_i,
  input  logic           in_valid_i,
  input  logic [W-1:0]   in_data_i,
  output logic           in_ready_o,
  output logic           wr_en_o,
  output logic [AW-1:0]  wr_addr_o,
  output logic [W-1:0]   wr_data_o,
  output logic           hold_o,
  input  logic           done_i,
  output logic [WCW-1:0] words_o,
  output logic           ovf_o,
  output logic [CNT_W-1:0] dur_o,
  output logic [CNT_W-1:0] arr_o,
  output logic [CNT_W-1:0] evn_o,
  output logic [CNT_W-1:0] spn_o
);

  localparam logic [WCW-1:0] FULL = WCW'(DEPTH);

  col_state_e       st_q, st_d;
  logic [WCW-1:0]   wcnt_q, wcnt_d;
  logic             ovf_q, ovf_d;
  logic [CNT_W-1:0] ts_q, ts_d;
  logic [CNT_W-1:0] dur_q, dur_d;
  logic [CNT_W-1:0] arr_q, arr_d;
  logic [CNT_W-1:0] evc_q, evc_d;
  logic [CNT_W-1:0] spc_q, spc_d;
  logic [CNT_W-1:0] evn_q, evn_d;
  logic [CNT_W-1:0] spn_q, spn_d;
  logic             wr_en;

  // next-state logic
  always_comb begin
    st_d   = st_q;
    wcnt_d = wcnt_q;
    ovf_d  = ovf_q;
    dur_d  = dur_q;
    arr_d  = arr_q;
    evc_d  = evc_q;
    spc_d  = spc_q;
    evn_d  = evn_q;
    spn_d  = spn_q;
    ts_d   = ts_q + 1'b1;
    wr_en  = 1'b0;
    unique case (st_q)
      COL_IDLE: begin
        if (start_i) begin
          st_d   = COL_RUN;
          wcnt_d = '0;
          ovf_d  = 1'b0;
          dur_d  = '0;
          arr_d  = ts_q;
        end
      end
      COL_RUN: begin
        dur_d = dur_q + 1'b1;
        if (in_valid_i) begin
          if (wcnt_q < FULL) begin
            wr_en  = 1'b1;
            wcnt_d = wcnt_q + 1'b1;
          end else begin
            ovf_d = 1'b1;
          end
        end
        if (end_i) begin
          st_d  = COL_HOLD;
          evn_d = evc_q;
          spn_d = spc_q;
          evc_d = evc_q + 1'b1;
        end
      end
      COL_HOLD: begin
        if (done_i) begin
          st_d = COL_IDLE;
        end
      end
      default: st_d = COL_IDLE;
    endcase
    if (spill_i) begin
      spc_d = spc_q + 1'b1;
      evc_d = '0;
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= COL_IDLE;
      wcnt_q <= '0;
      ovf_q  <= 1'b0;
      ts_q   <= '0;
      dur_q  <= '0;
      arr_q  <= '0;
      evc_q  <= '0;
      spc_q  <= '0;
      evn_q  <= '0;
      spn_q  <= '0;
    end else begin
      st_q   <= st_d;
      wcnt_q <= wcnt_d;
      ovf_q  <= ovf_d;
      ts_q   <= ts_d;
      dur_q  <= dur_d;
      arr_q  <= arr_d;
      evc_q  <= evc_d;
      spc_q  <= spc_d;
      evn_q  <= evn_d;
      spn_q  <= spn_d;
    end
  end

  assign in_ready_o = (st_q == COL_RUN);
  assign wr_en_o    = wr_en;
  assign wr_addr_o  = wcnt_q[AW-1:0];
  assign wr_data_o  = in_data_i;
  assign hold_o     = (st_q == COL_HOLD);
  assign words_o    = wcnt_q;
  assign ovf_o      = ovf_q;
  assign dur_o      = dur_q;
  assign arr_o      = arr_q;
  assign evn_o      = evn_q;
  assign spn_o      = spn_q;

  // R7
  ovf_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> (wcnt_q == FULL));

  // R1
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |-> (st_q == COL_HOLD));

endmodule

// File: rtl/evt_emit.sv
module evt_emit
  import evt_framer_pkg::*;
#(
  parameter int DEPTH        = 256,
  parameter int W            = 32,
  parameter int CNT_W        = 32,
  parameter logic [W-1:0] MARKER = 32'hEEEE_EEEE,
  localparam int AW          = $clog2(DEPTH),
  localparam int WCW         = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_i,
  input  logic [WCW-1:0]   words_i,
  input  logic             ovf_i,
  input  logic [CNT_W-1:0] dur_i,
  input  logic [CNT_W-1:0] arr_i,
  input  logic [CNT_W-1:0] evn_i,
  input  logic [CNT_W-1:0] spn_i,
  output logic [AW-1:0]    rd_addr_o,
  input  logic [W-1:0]     rd_data_i,
  output logic             out_valid_o,
  output logic [W-1:0]     out_data_o,
  input  logic             out_ready_i,
  output logic             done_o
);

  localparam logic [WCW-1:0] HDR_LAST = WCW'(HDR_WORDS - 1);
  localparam logic [WCW-1:0] TRL_LAST = WCW'(TRL_WORDS - 1);

  em_phase_e      ph_q, ph_d;
  logic [WCW-1:0] idx_q, idx_d;
  logic           fire;
  logic           done;
  logic [W-1:0]   tot_bytes;
  logic [W-1:0]   pay_bytes;
  logic [W-1:0]   err_word;

  assign fire = (ph_q != EM_IDLE) && out_ready_i;

  // next-state logic
  always_comb begin
    ph_d  = ph_q;
    idx_d = idx_q;
    done  = 1'b0;
    unique case (ph_q)
      EM_IDLE: begin
        if (hold_i) begin
          ph_d  = EM_HDR;
          idx_d = '0;
        end
      end
      EM_HDR: begin
        if (fire) begin
          if (idx_q == HDR_LAST) begin
            idx_d = '0;
            ph_d  = (words_i == '0) ? EM_TRL : EM_PAY;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      EM_PAY: begin
        if (fire) begin
          if (idx_q == words_i - 1'b1) begin
            idx_d = '0;
            ph_d  = EM_TRL;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      EM_TRL: begin
        if (fire) begin
          if (idx_q == TRL_LAST) begin
            idx_d = '0;
            ph_d  = EM_IDLE;
            done  = 1'b1;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      default: ph_d = EM_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= EM_IDLE;
      idx_q <= '0;
    end else begin
      ph_q  <= ph_d;
      idx_q <= idx_d;
    end
  end

  // frame word selection
  always_comb begin
    tot_bytes = (W'(words_i) + W'(OVH_WORDS)) << 2;
    pay_bytes = W'(words_i) << 2;
    err_word  = '0;
    err_word[ERR_OVF_BIT] = ovf_i;
    out_data_o = '0;
    unique case (ph_q)
      EM_HDR: begin
        unique case (idx_q)
          WCW'(0): out_data_o = tot_bytes;
          WCW'(1): out_data_o = W'(dur_i);
          WCW'(2): out_data_o = W'(evn_i);
          WCW'(3): out_data_o = W'(spn_i);
          default: out_data_o = W'(arr_i);
        endcase
      end
      EM_PAY: out_data_o = rd_data_i;
      EM_TRL: begin
        unique case (idx_q)
          WCW'(0): out_data_o = MARKER;
          WCW'(1): out_data_o = pay_bytes;
          default: out_data_o = err_word;
        endcase
      end
      default: out_data_o = '0;
    endcase
  end

  assign out_valid_o = (ph_q != EM_IDLE);
  assign rd_addr_o   = idx_q[AW-1:0];
  assign done_o      = done;

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

  // R1
  trl_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ph_q == EM_TRL) && ($past(ph_q) != EM_TRL)) |-> $past(fire));

endmodule

// File: rtl/evt_framer.sv
module evt_framer
  import evt_framer_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int W     = 32,
  parameter int CNT_W = 32,
  parameter logic [W-1:0] MARKER = 32'hEEEE_EEEE,
  localparam int AW   = $clog2(DEPTH),
  localparam int WCW  = AW + 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         spill_i,
  input  logic         evt_start_i,
  input  logic         evt_end_i,
  input  logic         in_valid_i,
  input  logic [W-1:0] in_data_i,
  output logic         in_ready_o,
  output logic         out_valid_o,
  output logic [W-1:0] out_data_o,
  input  logic         out_ready_i
);

  logic             wr_en;
  logic [AW-1:0]    wr_addr;
  logic [W-1:0]     wr_data;
  logic [AW-1:0]    rd_addr;
  logic [W-1:0]     rd_data;
  logic             hold;
  logic             done;
  logic [WCW-1:0]   words;
  logic             ovf;
  logic [CNT_W-1:0] dur;
  logic [CNT_W-1:0] arr;
  logic [CNT_W-1:0] evn;
  logic [CNT_W-1:0] spn;

  evt_collect #(.DEPTH(DEPTH), .W(W), .CNT_W(CNT_W)) u_collect (
    .clk        (clk),
    .rst_n      (rst_n),
    .spill_i    (spill_i),
    .start_i    (evt_start_i),
    .end_i      (evt_end_i),
    .in_valid_i (in_valid_i),
    .in_data_i  (in_data_i),
    .in_ready_o (in_ready_o),
    .wr_en_o    (wr_en),
    .wr_addr_o  (wr_addr),
    .wr_data_o  (wr_data),
    .hold_o     (hold),
    .done_i     (done),
    .words_o    (words),
    .ovf_o      (ovf),
    .dur_o      (dur),
    .arr_o      (arr),
    .evn_o      (evn),
    .spn_o      (spn)
  );

  evt_buf #(.DEPTH(DEPTH), .W(W)) u_buf (
    .clk       (clk),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data)
  );

  evt_emit #(.DEPTH(DEPTH), .W(W), .CNT_W(CNT_W), .MARKER(MARKER)) u_emit (
    .clk         (clk),
    .rst_n       (rst_n),
    .hold_i      (hold),
    .words_i     (words),
    .ovf_i       (ovf),
    .dur_i       (dur),
    .arr_i       (arr),
    .evn_i       (evn),
    .spn_i       (spn),
    .rd_addr_o   (rd_addr),
    .rd_data_i   (rd_data),
    .out_valid_o (out_valid_o),
    .out_data_o  (out_data_o),
    .out_ready_i (out_ready_i),
    .done_o      (done)
  );

  // R9
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> !in_ready_o);

endmodule

// File: tb/evt_framer_bench.sv
`timescale 1ns/1ps
module evt_framer_bench;

  localparam int DEPTH = 256;
  localparam logic [31:0] MARK = 32'hEEEE_EEEE;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        spill, evt_start, evt_end, in_valid, in_ready;
  logic [31:0] in_data;
  logic        out_valid, out_ready;
  logic [31:0] out_data;

  always #4 clk = ~clk;

  evt_framer u_evt_framer (
    .clk         (clk),
    .rst_n       (rst_n),
    .spill_i     (spill),
    .evt_start_i (evt_start),
    .evt_end_i   (evt_end),
    .in_valid_i  (in_valid),
    .in_data_i   (in_data),
    .in_ready_o  (in_ready),
    .out_valid_o (out_valid),
    .out_data_o  (out_data),
    .out_ready_i (out_ready)
  );

  int unsigned cyc = 0;
  int unsigned wd  = 0;
  int n_cmp = 0;
  int n_bad = 0;
  int exp_evn = 0;
  int exp_spill = 0;
  bit ready_mode = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic [31:0] exp_q [$];
  string       tag_q [$];
  bit          stall_prev = 1'b0;
  logic [31:0] stall_data = '0;

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  // downstream ready pattern
  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready <= ready_mode ? (lfsr[0] | lfsr[1]) : 1'b1;
  end

  // monitor
  always begin
    @(negedge clk);
    #1;
    if (rst_n) begin
      if (stall_prev) begin
        chk("R8 valid held under stall", {31'b0, out_valid}, 32'd1);
        chk("R8 data held under stall", out_data, stall_data);
      end
      stall_prev = out_valid && !out_ready;
      stall_data = out_data;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk("R1 unexpected frame word", out_data, 32'hxxxx_xxxx);
        end else begin
          chk(tag_q.pop_front(), out_data, exp_q.pop_front());
        end
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    wd++;
    if (wd == 150000) begin
      n_bad++;
      $display("FAIL R1 watchdog: cycles %0d expected below %0d", wd, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  function automatic logic [31:0] pdata(input int id, input int i);
    return {8'(id), 24'(i)} ^ 32'h5A00_0000;
  endfunction

  task automatic run_event(input int id, input int n, input bit gaps,
                           input int tail, input bit probe);
    int unsigned cs, ce;
    int stored;
    stored = (n > DEPTH) ? DEPTH : n;
    evt_start = 1'b1;
    cs = cyc;
    @(negedge clk);
    evt_start = 1'b0;
    chk("R9 ready while collecting", {31'b0, in_ready}, 32'd1);
    for (int i = 0; i < n; i++) begin
      if (gaps && (i % 3 == 1)) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_data  = pdata(id, i);
      @(negedge clk);
    end
    in_valid = 1'b0;
    repeat (tail) @(negedge clk);
    evt_end = 1'b1;
    ce = cyc;
    push(32'(4 * (8 + stored)), "R2 header total bytes");
    push(32'(ce - cs), "R3 header duration");
    push(32'(exp_evn), "R5 header event number");
    push(32'(exp_spill), "R5 header spill number");
    push(32'(cs), "R4 header arrival time");
    for (int i = 0; i < stored; i++) push(pdata(id, i), "R1 payload word");
    push(MARK, "R6 trailer marker");
    push(32'(4 * stored), "R2 trailer payload bytes");
    push((n > DEPTH) ? 32'd1 : 32'd0, "R7 trailer error field");
    exp_evn++;
    @(negedge clk);
    evt_end = 1'b0;
    if (probe) begin
      @(negedge clk);
      evt_start = 1'b1;
      in_valid  = 1'b1;
      in_data   = 32'hDEAD_0001;
      chk("R9 ready low while frame pending", {31'b0, in_ready}, 32'd0);
      @(negedge clk);
      evt_start = 1'b0;
      in_valid  = 1'b0;
    end
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R1 valid low between frames", {31'b0, out_valid}, 32'd0);
  endtask

  task automatic do_spill();
    spill = 1'b1;
    @(negedge clk);
    spill = 1'b0;
    exp_spill++;
    exp_evn = 0;
  endtask

  initial begin
    rst_n = 1'b0;
    spill = 1'b0; evt_start = 1'b0; evt_end = 1'b0;
    in_valid = 1'b0; in_data = '0;
    repeat (3) @(negedge clk);
    chk("R10 out_valid in reset", {31'b0, out_valid}, 32'd0);
    chk("R10 in_ready in reset", {31'b0, in_ready}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_event(1, 4, 1'b0, 0, 1'b0);
    run_event(2, 0, 1'b0, 2, 1'b0);
    ready_mode = 1'b1;
    run_event(3, 20, 1'b1, 3, 1'b1);

    // stray end strobe and data while idle: R9
    evt_end = 1'b1; in_valid = 1'b1; in_data = 32'hDEAD_0002;
    @(negedge clk);
    evt_end = 1'b0; in_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 no frame after stray end", {31'b0, out_valid}, 32'd0);
    run_event(4, 3, 1'b0, 1, 1'b0);

    do_spill();
    run_event(5, 2, 1'b0, 0, 1'b0);
    run_event(6, 7, 1'b1, 0, 1'b1);
    do_spill();
    do_spill();
    run_event(7, 5, 1'b0, 4, 1'b0);

    run_event(8, DEPTH + 5, 1'b0, 0, 1'b1);
    ready_mode = 1'b0;
    run_event(9, DEPTH, 1'b0, 0, 1'b0);

    chk("R1 scoreboard drained", 32'(exp_q.size()), 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule